// File: doc/BRIEF.md
# Multi-converter sync and settling tracker

This block sits beside a bank of delta-sigma converters that all run from one master clock. A system-level strobe arrives with no fixed phase to that clock. The block retimes the strobe into the master clock domain and turns each rising edge into an active-low restart pulse on `sync_n`. The pulse line changes only on falling edges of the master clock, so every converter samples the same transition with half a period of setup. Pulling the line low zeroes each converter's modulator count and holds the modulator. Releasing the line starts all converters on the same edge. The pulse resets only the modulator count, and nothing here touches any converter's result register.

The block also follows how far the converters' digital filters have settled. It counts conversion-done events, not elapsed time, because a conversion that is interrupted by a restart runs longer than normal by an amount that cannot be known in advance.
- After an input change with no restart, `data_valid` comes on with the sixth conversion-done event.
- After a restart, the first conversion-done event ends a conversion built only from new samples. Four more events then complete the settling.

Top module: `sync_settle_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) drives `sync_n` high, `hold` low and `data_valid` low. Afterwards the tracker behaves as after an input change with no restart (R6).
- R2: With the default of two synchronizer stages, a strobe raised before a rising clock edge leaves `sync_n` high through the next falling edges. `sync_n` goes low on the falling edge that follows the third rising edge after the strobe went high.
- R3: An isolated strobe rising edge holds `sync_n` low for exactly `MIN_PULSE` master clock periods (default 2). Every low period lasts at least that long.
- R4: `hold` is high exactly when `sync_n` is low, as seen at every rising clock edge.
- R5: A new strobe rising edge that is recognised while a pulse is active restarts the width timer. A strobe pattern of high, low, high on three consecutive cycles therefore gives one unbroken low period of `MIN_PULSE`+2 cycles.
- R6: After `input_changed` with no restart, `data_valid` rises at the clock edge that samples the sixth `conv_done` pulse (`PLAIN_SETTLE`+1). It stays low before that edge.
- R7: After a restart pulse ends, `data_valid` rises at the clock edge that samples the fifth `conv_done` pulse: one pulse for the restarted conversion and then `SYNC_EXTRA` = 4 more.
- R8: A restart pulse or an `input_changed` pulse clears `data_valid` and the event count. `conv_done` pulses that arrive while `sync_n` is low are not counted.
- R9: When `input_changed` and `conv_done` are high in the same cycle, the input change wins. The count restarts at zero and that `conv_done` is not counted.
- R10: Once `data_valid` is high, it stays high through further `conv_done` pulses until the next input change or restart.
- R11: Only rising edges of the strobe matter. A strobe held high for many cycles gives one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock shared with every converter |
| rst | input | 1 | Synchronous reset, active high |
| strobe_async | input | 1 | System sync request, asynchronous to `clk`, acts on its rising edge |
| input_changed | input | 1 | One-cycle pulse: the analog input has changed |
| conv_done | input | 1 | One-cycle pulse: a converter finished a conversion |
| sync_n | output | 1 | Active-low restart line to all converters, updated on falling `clk` edges |
| hold | output | 1 | High while the converters are held in restart |
| data_valid | output | 1 | High once the filters have settled on the current input |

## Verification
Two of the block's functions can land in the same cycle. In the first case, a conversion-done event arrives in the cycle of an input change. In the second, a conversion-done event arrives while a restart pulse is holding the converters, and in that case it must be discarded. The bench provokes both on purpose and also mixes them into random runs. It judges them by whether `data_valid` rises exactly at the count its own model derives from R6, R7 and R9. A re-trigger during an active pulse is judged by the length of the single low period it produces.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic {
    MODE_PLAIN  = 1'b0,
    MODE_SYNCED = 1'b1
  } settle_mode_e;

  // Number of conversion-done events up to and including the one that
  // makes the output trustworthy.
  function automatic int settle_target(settle_mode_e mode, int plain_settle,
                                       int sync_extra);
    if (mode == MODE_SYNCED) return 1 + sync_extra;
    return plain_settle + 1;
  endfunction

  function automatic int max_target(int plain_settle, int sync_extra);
    int a;
    int b;
    a = plain_settle + 1;
    b = sync_extra + 1;
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold 0 .. max_target inclusive.
  function automatic int count_width(int plain_settle, int sync_extra);
    int w;
    w = $clog2(max_target(plain_settle, sync_extra) + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/sst_strobe_sync.sv
module sst_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_async,
  output logic rise
);

  logic [SYNC_STAGES-1:0] chain;
  logic                   last_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= din_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[SYNC_STAGES-1];
  end

  assign rise = chain[SYNC_STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R11

endmodule

// File: rtl/sst_pulse_gen.sv
module sst_pulse_gen #(
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic hold_req,
  output logic sync_n,
  output logic hold
);

  localparam int PW_W = (MIN_PULSE < 1) ? 1 : $clog2(MIN_PULSE + 1);

  logic [PW_W-1:0] width_cnt;

  // Rising-edge domain: a trigger (re)loads the width timer.
  always_ff @(posedge clk) begin
    if (rst)                  width_cnt <= '0;
    else if (trig)            width_cnt <= PW_W'(MIN_PULSE);
    else if (width_cnt != '0) width_cnt <= width_cnt - PW_W'(1);
  end

  assign hold_req = (width_cnt != '0);

  // Falling-edge retiming: the line moves half a period before the
  // converters sample it.
  always_ff @(negedge clk) begin
    if (rst) begin
      sync_n <= 1'b1;
      hold   <= 1'b0;
    end else begin
      sync_n <= ~hold_req;
      hold   <= hold_req;
    end
  end

  // Checker state: consecutive rising edges that saw the line low.
  logic [7:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || sync_n)        low_run <= '0;
    else if (low_run != 8'hFF) low_run <= low_run + 8'd1;
  end

  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> (int'(low_run) >= MIN_PULSE)); // R3

  AST_HOLD_MIRROR: assert property (@(posedge clk) disable iff (rst)
    hold == !sync_n); // R4

endmodule

// File: rtl/sst_settle_track.sv
module sst_settle_track
  import sst_pkg::*;
#(
  parameter int PLAIN_SETTLE = 5,
  parameter int SYNC_EXTRA   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic input_chg,
  input  logic done,
  output logic valid
);

  localparam int CNT_W = count_width(PLAIN_SETTLE, SYNC_EXTRA);

  logic [CNT_W-1:0] cnt;
  settle_mode_e     mode;
  int               tgt;

  assign tgt = settle_target(mode, PLAIN_SETTLE, SYNC_EXTRA);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      mode  <= MODE_PLAIN;
      valid <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      mode  <= MODE_SYNCED;
      valid <= 1'b0;
    end else if (input_chg) begin
      cnt   <= '0;
      mode  <= MODE_PLAIN;
      valid <= 1'b0;
    end else if (done && (int'(cnt) < tgt)) begin
      cnt   <= cnt + CNT_W'(1);
      valid <= ((int'(cnt) + 1) == tgt);
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) || (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1))); // R8

  AST_VALID_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(done)); // R6

  AST_CHANGE_WINS: assert property (@(posedge clk) disable iff (rst)
    (input_chg && !restart) |=> (!valid && cnt == '0)); // R9

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    (valid && !restart && !input_chg) |=> valid); // R10

endmodule

// File: rtl/sync_settle_ctrl.sv
module sync_settle_ctrl #(
  parameter int MIN_PULSE    = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int PLAIN_SETTLE = 5,
  parameter int SYNC_EXTRA   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_async,
  input  logic input_changed,
  input  logic conv_done,
  output logic sync_n,
  output logic hold,
  output logic data_valid
);

  logic strobe_rise;
  logic hold_req;

  sst_strobe_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .din_async(strobe_async),
    .rise     (strobe_rise)
  );

  sst_pulse_gen #(
    .MIN_PULSE(MIN_PULSE)
  ) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .trig    (strobe_rise),
    .hold_req(hold_req),
    .sync_n  (sync_n),
    .hold    (hold)
  );

  sst_settle_track #(
    .PLAIN_SETTLE(PLAIN_SETTLE),
    .SYNC_EXTRA  (SYNC_EXTRA)
  ) u_settle (
    .clk      (clk),
    .rst      (rst),
    .restart  (hold_req),
    .input_chg(input_changed),
    .done     (conv_done),
    .valid    (data_valid)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (sync_n && !hold && !data_valid)); // R1

  AST_VALID_LOW_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sync_n |=> !data_valid); // R8

  AST_TRIG_LOWERS_LINE: assert property (@(posedge clk) disable iff (rst)
    strobe_rise |=> hold_req); // R2

endmodule

// File: tb/sync_settle_ctrl_tb.sv
module sync_settle_ctrl_tb_top;

  localparam int MIN_PULSE    = 2;
  localparam int PLAIN_SETTLE = 5;
  localparam int SYNC_EXTRA   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe_async = 1'b0;
  logic input_changed = 1'b0;
  logic conv_done = 1'b0;
  logic sync_n;
  logic hold;
  logic data_valid;

  int checks = 0;
  int fails = 0;
  int bcount = 0;
  bit bsynced = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sync_settle_ctrl #(
    .MIN_PULSE   (MIN_PULSE),
    .SYNC_STAGES (2),
    .PLAIN_SETTLE(PLAIN_SETTLE),
    .SYNC_EXTRA  (SYNC_EXTRA)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .strobe_async (strobe_async),
    .input_changed(input_changed),
    .conv_done    (conv_done),
    .sync_n       (sync_n),
    .hold         (hold),
    .data_valid   (data_valid)
  );

  function automatic int exp_target(bit synced);
    return synced ? (SYNC_EXTRA + 1) : (PLAIN_SETTLE + 1);
  endfunction

  function automatic bit exp_valid(int c, bit synced);
    return c >= exp_target(synced);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive and sample 2 ns after a falling edge: clear of both clock edges.
  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic do_done();
    string req;
    tick();
    conv_done = 1'b1;
    tick();
    conv_done = 1'b0;
    if (bcount >= exp_target(bsynced)) req = "R10";
    else if (bsynced) req = "R7";
    else req = "R6";
    if (bcount < exp_target(bsynced)) bcount++;
    check(req, int'(data_valid), int'(exp_valid(bcount, bsynced)));
  endtask

  task automatic do_change(bit with_done);
    tick();
    input_changed = 1'b1;
    conv_done = with_done;
    tick();
    input_changed = 1'b0;
    conv_done = 1'b0;
    bcount = 0;
    bsynced = 1'b0;
    check(with_done ? "R9" : "R8", int'(data_valid), 0);
  endtask

  task automatic do_sync(bit extend, bit done_in_hold);
    int low;
    tick();
    strobe_async = 1'b1;
    tick();
    if (extend) strobe_async = 1'b0;
    tick();
    if (extend) strobe_async = 1'b1;
    check("R2", int'(sync_n), 1);
    tick();
    check("R2", int'(sync_n), 0);
    check("R4", int'(hold), 1);
    low = 0;
    while (sync_n == 1'b0 && low < 100) begin
      low++;
      conv_done = (done_in_hold && low == 1);
      tick();
    end
    conv_done = 1'b0;
    if (extend) check("R5", low, MIN_PULSE + 2);
    else        check("R3", low, MIN_PULSE);
    check("R4", int'(hold), 0);
    bcount = 0;
    bsynced = 1'b1;
    check("R8", int'(data_valid), 0);
    strobe_async = 1'b0;
    repeat (4) tick();
    check("R11", int'(sync_n), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    check("R1", int'(sync_n), 1);
    check("R1", int'(hold), 0);
    check("R1", int'(data_valid), 0);
    rst = 1'b0;
    tick();

    // After reset: plain settling.
    for (int i = 0; i < PLAIN_SETTLE + 2; i++) do_done();

    do_change(1'b0);
    for (int i = 0; i < PLAIN_SETTLE + 3; i++) do_done();

    do_sync(1'b0, 1'b0);
    for (int i = 0; i < SYNC_EXTRA + 3; i++) do_done();

    // Long strobe: single pulse only.
    do_change(1'b0);
    do_sync(1'b0, 1'b1);
    for (int i = 0; i < SYNC_EXTRA + 2; i++) do_done();

    do_sync(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) do_done();
    do_change(1'b1);
    for (int i = 0; i < PLAIN_SETTLE + 2; i++) do_done();

    // Mid-run reset.
    tick();
    rst = 1'b1;
    repeat (2) tick();
    check("R1", int'(data_valid), 0);
    check("R1", int'(sync_n), 1);
    rst = 1'b0;
    bcount = 0;
    bsynced = 1'b0;
    tick();

    for (int n = 0; n < 600; n++) begin
      int pick;
      pick = int'($urandom_range(0, 15));
      if (pick < 10)       do_done();
      else if (pick == 10) do_change(1'b0);
      else if (pick == 11) do_change(1'b1);
      else if (pick == 12) do_sync(1'b0, 1'b0);
      else if (pick == 13) do_sync(1'b0, 1'b1);
      else if (pick == 14) do_sync(1'b1, 1'b0);
      else                 repeat (int'($urandom_range(1, 4))) tick();
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule